// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge Unit

This unit is the guest-facing side of a virtualized interrupt controller for a single virtual CPU context. It does not sample interrupt lines. A hypervisor loads a small bank of list-register entries through a dedicated load port. Each entry carries a virtual interrupt ID, a source CPU ID, a priority, a two-bit state, a hardware-linked flag and an end-of-interrupt notify flag.

The guest reaches the unit over a simple register bus with four word addresses. An acknowledge read selects the best pending entry, returns its identity and makes that entry active. An end-of-interrupt (EOI) write names an interrupt by virtual ID and source CPU, finds the active entry that matches and retires it. When a retired entry asked for notification, the unit emits a one-cycle pulse carrying the entry index, which the maintenance logic can consume.

Top module: `virq_ack_unit`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid, the interface enable is 0, the priority mask holds all ones, and bus_rvalid, ack_hw_err and eoi_pulse are 0.
- R2: Address 0 is the control register (bit 0 is the interface enable) and address 1 is the priority mask (low PRIO_W bits). Both are written from bus_wdata and read back zero-extended. A read returns its data on bus_rdata with bus_rvalid high in the cycle after the request.
- R3: An acknowledge read (address 2) returns 1023 and changes no entry when the enable is 0 or when no entry is eligible.
- R4: A granted acknowledge returns the virtual ID in bits 9:0 and the source CPU in bits 12:10, with all other bits 0. The winning entry moves from pending (01) to active (10). The state code for invalid is 00 and for pending-and-active is 11.
- R5: An entry is eligible only if its state is 01 and its priority is numerically below the priority mask. Among eligible entries the lowest priority value wins, and on a tie the lowest index wins.
- R6: An EOI write (address 3) takes the virtual ID from bits 9:0 and the source CPU from bits 12:10. It retires the lowest-indexed entry whose state is 10 or 11 and whose ID and CPU both match. State 10 becomes 00, and state 11 becomes 01.
- R7: An EOI write that matches no entry changes no entry and produces no pulse.
- R8: If the winning entry has its hardware-linked flag set, the read returns 1023, no entry changes, and ack_hw_err is high for exactly the cycle after the request.
- R9: When an EOI retires an entry whose notify flag is set, eoi_pulse is high for exactly the cycle after the write and eoi_idx holds that entry's index. A retired entry without the flag produces no pulse.
- R10: A load writes every field of the addressed entry, and the new values are visible in the next cycle. In the same cycle, a load overrides any acknowledge or EOI update to that entry. lr_state shows entry i's state at bits 2i+1:2i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 control, 1 priority mask, 2 acknowledge, 3 EOI |
| bus_wdata | input | 13 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, cycle after the request |
| lr_we | input | 1 | Load strobe for one entry |
| lr_idx | input | IDX_W | Entry to load |
| lr_vid | input | 10 | Virtual interrupt ID to load |
| lr_cpu | input | 3 | Source CPU ID to load |
| lr_prio | input | PRIO_W | Priority to load |
| lr_st | input | 2 | State to load |
| lr_hw | input | 1 | Hardware-linked flag to load |
| lr_notify | input | 1 | EOI notify flag to load |
| lr_state | output | 2*NUM_LR | Current state of every entry |
| ack_hw_err | output | 1 | Acknowledge hit a hardware-linked entry |
| eoi_pulse | output | 1 | A notify-flagged entry was retired |
| eoi_idx | output | IDX_W | Index of the entry retired with notify |

## Verification
The bench builds the unit with NUM_LR=4 and PRIO_W=5. Random priorities are drawn only from 0..7, and virtual IDs come from a pool of four values. This makes priority ties and duplicate ID/CPU pairs across entries frequent, so the lowest-index rules for both acknowledge selection and EOI matching are exercised. Mask values are drawn near the priority range, so entries sit on both sides of the strict-below threshold. A directed case drives a load and an acknowledge at the same entry in one cycle.

// File: rtl/vack_pkg.sv
// Shared constants and encodings for the virtual interrupt acknowledge unit.
// Assumes a fixed 10-bit virtual ID and 3-bit source CPU field.
package vack_pkg;
    localparam int VID_W = 10;
    localparam int SRC_W = 3;
    localparam int WD_W  = VID_W + SRC_W;
    localparam logic [31:0] SPURIOUS_ID = 32'd1023;

    typedef enum logic [1:0] {
        ST_INV  = 2'b00,
        ST_PEND = 2'b01,
        ST_ACT  = 2'b10,
        ST_PACT = 2'b11
    } lr_st_e;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_PMASK = 2'd1,
        RA_ACK   = 2'd2,
        RA_EOI   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/vack_arbiter.sv
// Picks the pending entry to acknowledge: strict-below-mask, lowest priority
// value, ties to the lowest index. Purely combinational; clk/rst_n feed the
// local assertions only.
module vack_arbiter
    import vack_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int PRIO_W = 5,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lr_st_e            st_i   [NUM_LR],
    input  logic [PRIO_W-1:0] prio_i [NUM_LR],
    input  logic [PRIO_W-1:0] pmask_i,
    output logic              win_v,
    output logic [IDX_W-1:0]  win_idx
);
    logic [PRIO_W-1:0] best;

    // Linear scan; strict compare keeps the earlier index on ties.
    always_comb begin
        win_v   = 1'b0;
        win_idx = '0;
        best    = '1;
        for (int i = 0; i < NUM_LR; i++) begin
            if (st_i[i] == ST_PEND && prio_i[i] < pmask_i &&
                (!win_v || prio_i[i] < best)) begin
                win_v   = 1'b1;
                win_idx = IDX_W'(i);
                best    = prio_i[i];
            end
        end
    end

    // R5
    win_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_v |-> (st_i[win_idx] == ST_PEND && prio_i[win_idx] < pmask_i));
endmodule

// File: rtl/vack_matcher.sv
// Finds the lowest-indexed active or pending-and-active entry whose
// virtual ID and source CPU equal the EOI value. Combinational.
module vack_matcher
    import vack_pkg::*;
#(
    parameter int NUM_LR = 4,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lr_st_e           st_i  [NUM_LR],
    input  logic [VID_W-1:0] vid_i [NUM_LR],
    input  logic [SRC_W-1:0] cpu_i [NUM_LR],
    input  logic [VID_W-1:0] q_vid,
    input  logic [SRC_W-1:0] q_cpu,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);
    // Scan from the top so the lowest matching index is kept last.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_LR - 1; i >= 0; i--) begin
            if (st_i[i][1] && vid_i[i] == q_vid && cpu_i[i] == q_cpu) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    // R6
    hit_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (st_i[hit_idx][1] && vid_i[hit_idx] == q_vid && cpu_i[hit_idx] == q_cpu));
endmodule

// File: rtl/vack_lr_bank.sv
// Storage for the list-register entries and their state transitions.
// Assumes acknowledge and retire never arrive in the same cycle; a load
// to an entry overrides either update to that entry.
module vack_lr_bank
    import vack_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int PRIO_W = 5,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [VID_W-1:0]  ld_vid,
    input  logic [SRC_W-1:0]  ld_cpu,
    input  logic [PRIO_W-1:0] ld_prio,
    input  logic [1:0]        ld_st,
    input  logic              ld_hw,
    input  logic              ld_nt,
    input  logic              take_v,
    input  logic [IDX_W-1:0]  take_idx,
    input  logic              ret_v,
    input  logic [IDX_W-1:0]  ret_idx,
    output lr_st_e            st_o   [NUM_LR],
    output logic [VID_W-1:0]  vid_o  [NUM_LR],
    output logic [SRC_W-1:0]  cpu_o  [NUM_LR],
    output logic [PRIO_W-1:0] prio_o [NUM_LR],
    output logic              hw_o   [NUM_LR],
    output logic              eoi_pulse_o,
    output logic [IDX_W-1:0]  eoi_idx_o
);
    logic nt_q [NUM_LR];

    // Per-entry field storage with load priority over bus-driven updates.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_LR; i++) begin
            if (!rst_n) begin
                st_o[i]   <= ST_INV;
                vid_o[i]  <= '0;
                cpu_o[i]  <= '0;
                prio_o[i] <= '0;
                hw_o[i]   <= 1'b0;
                nt_q[i]   <= 1'b0;
            end else if (ld_we && ld_idx == IDX_W'(i)) begin
                st_o[i]   <= lr_st_e'(ld_st);
                vid_o[i]  <= ld_vid;
                cpu_o[i]  <= ld_cpu;
                prio_o[i] <= ld_prio;
                hw_o[i]   <= ld_hw;
                nt_q[i]   <= ld_nt;
            end else if (take_v && take_idx == IDX_W'(i)) begin
                st_o[i] <= ST_ACT;
            end else if (ret_v && ret_idx == IDX_W'(i)) begin
                st_o[i] <= (st_o[i] == ST_PACT) ? ST_PEND : ST_INV;
            end
        end
    end

    // Notify pulse for a retired entry whose flag was set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_pulse_o <= 1'b0;
            eoi_idx_o   <= '0;
        end else begin
            eoi_pulse_o <= ret_v && nt_q[ret_idx];
            eoi_idx_o   <= ret_idx;
        end
    end

    // R4
    ack_marks_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_v && !(ld_we && ld_idx == take_idx)) |=> st_o[$past(take_idx)] == ST_ACT);

    // R9
    pulse_after_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_pulse_o |-> $past(ret_v));
endmodule

// File: rtl/virq_ack_unit.sv
// Guest-facing acknowledge/EOI unit for one virtual CPU context.
// Register bus: one-cycle strobes, reads answered the following cycle.
// Assumes a single bus access per cycle; list entries loaded by the hypervisor.
module virq_ack_unit
    import vack_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int PRIO_W = 5,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [1:0]          bus_addr,
    input  logic [WD_W-1:0]     bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid,
    input  logic                lr_we,
    input  logic [IDX_W-1:0]    lr_idx,
    input  logic [VID_W-1:0]    lr_vid,
    input  logic [SRC_W-1:0]    lr_cpu,
    input  logic [PRIO_W-1:0]   lr_prio,
    input  logic [1:0]          lr_st,
    input  logic                lr_hw,
    input  logic                lr_notify,
    output logic [2*NUM_LR-1:0] lr_state,
    output logic                ack_hw_err,
    output logic                eoi_pulse,
    output logic [IDX_W-1:0]    eoi_idx
);
    lr_st_e            st   [NUM_LR];
    logic [VID_W-1:0]  vid  [NUM_LR];
    logic [SRC_W-1:0]  cpu  [NUM_LR];
    logic [PRIO_W-1:0] prio [NUM_LR];
    logic              hw   [NUM_LR];

    logic              ctl_en;
    logic [PRIO_W-1:0] pmask;
    logic              win_v, hit;
    logic [IDX_W-1:0]  win_idx, hit_idx;
    logic              ack_rd, eoi_wr, grant, hw_block;
    logic [31:0]       rd_nxt;

    // Decode of the single-cycle bus strobe.
    always_comb begin
        ack_rd   = bus_req && !bus_we && bus_addr == RA_ACK;
        eoi_wr   = bus_req &&  bus_we && bus_addr == RA_EOI;
        grant    = ack_rd && ctl_en && win_v && !hw[win_idx];
        hw_block = ack_rd && ctl_en && win_v &&  hw[win_idx];
    end

    vack_arbiter #(.NUM_LR(NUM_LR), .PRIO_W(PRIO_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .st_i(st), .prio_i(prio), .pmask_i(pmask),
        .win_v(win_v), .win_idx(win_idx)
    );

    vack_matcher #(.NUM_LR(NUM_LR)) u_match (
        .clk(clk), .rst_n(rst_n), .st_i(st), .vid_i(vid), .cpu_i(cpu),
        .q_vid(bus_wdata[VID_W-1:0]), .q_cpu(bus_wdata[WD_W-1:VID_W]),
        .hit(hit), .hit_idx(hit_idx)
    );

    vack_lr_bank #(.NUM_LR(NUM_LR), .PRIO_W(PRIO_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .ld_we(lr_we), .ld_idx(lr_idx), .ld_vid(lr_vid), .ld_cpu(lr_cpu),
        .ld_prio(lr_prio), .ld_st(lr_st), .ld_hw(lr_hw), .ld_nt(lr_notify),
        .take_v(grant), .take_idx(win_idx),
        .ret_v(eoi_wr && hit), .ret_idx(hit_idx),
        .st_o(st), .vid_o(vid), .cpu_o(cpu), .prio_o(prio), .hw_o(hw),
        .eoi_pulse_o(eoi_pulse), .eoi_idx_o(eoi_idx)
    );

    // Flatten entry states for the hypervisor view.
    always_comb begin
        for (int i = 0; i < NUM_LR; i++) lr_state[2*i +: 2] = st[i];
    end

    // Control and priority-mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en <= 1'b0;
            pmask  <= '1;
        end else if (bus_req && bus_we) begin
            if (bus_addr == RA_CTRL)  ctl_en <= bus_wdata[0];
            if (bus_addr == RA_PMASK) pmask  <= bus_wdata[PRIO_W-1:0];
        end
    end

    // Read data selection for the access in flight.
    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            RA_CTRL:  rd_nxt = {31'b0, ctl_en};
            RA_PMASK: rd_nxt = 32'(pmask);
            RA_ACK:   rd_nxt = grant ? 32'({cpu[win_idx], vid[win_idx]}) : SPURIOUS_ID;
            default:  rd_nxt = '0;
        endcase
    end

    // Registered read response and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            ack_hw_err <= 1'b0;
        end else begin
            bus_rvalid <= bus_req && !bus_we;
            ack_hw_err <= hw_block;
            if (bus_req && !bus_we) bus_rdata <= rd_nxt;
        end
    end

    // R3
    spurious_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ack_rd && !ctl_en)) |-> bus_rdata == SPURIOUS_ID);

    // R8
    err_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hw_err |-> ($past(ack_rd && ctl_en) && bus_rdata == SPURIOUS_ID));

    // R2
    rvalid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_req && !bus_we));
endmodule

// File: tb/sim_virq_ack_unit.sv
module sim_virq_ack_unit;
    import vack_pkg::*;
    localparam int NLR = 4;
    localparam int PW  = 5;
    localparam int IW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic            bus_req = 0, bus_we = 0;
    logic [1:0]      bus_addr = 0;
    logic [12:0]     bus_wdata = 0;
    logic [31:0]     bus_rdata;
    logic            bus_rvalid;
    logic            lr_we = 0;
    logic [IW-1:0]   lr_idx = 0;
    logic [9:0]      lr_vid = 0;
    logic [2:0]      lr_cpu = 0;
    logic [PW-1:0]   lr_prio = 0;
    logic [1:0]      lr_st = 0;
    logic            lr_hw = 0, lr_notify = 0;
    logic [2*NLR-1:0] lr_state;
    logic            ack_hw_err, eoi_pulse;
    logic [IW-1:0]   eoi_idx;

    virq_ack_unit #(.NUM_LR(NLR), .PRIO_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .lr_we(lr_we), .lr_idx(lr_idx), .lr_vid(lr_vid),
        .lr_cpu(lr_cpu), .lr_prio(lr_prio), .lr_st(lr_st), .lr_hw(lr_hw),
        .lr_notify(lr_notify), .lr_state(lr_state), .ack_hw_err(ack_hw_err),
        .eoi_pulse(eoi_pulse), .eoi_idx(eoi_idx)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [9:0]    m_vid [NLR];
    logic [2:0]    m_cpu [NLR];
    logic [PW-1:0] m_prio[NLR];
    logic [1:0]    m_st  [NLR];
    logic          m_hw  [NLR];
    logic          m_nt  [NLR];
    logic          m_en;
    logic [PW-1:0] m_pm;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [2*NLR-1:0] m_pack();
        logic [2*NLR-1:0] v;
        for (int i = 0; i < NLR; i++) v[2*i +: 2] = m_st[i];
        return v;
    endfunction

    function automatic int m_win();
        int w = -1;
        for (int i = 0; i < NLR; i++)
            if (m_st[i] == 2'b01 && m_prio[i] < m_pm && (w < 0 || m_prio[i] < m_prio[w])) w = i;
        return w;
    endfunction

    function automatic int m_match(input logic [9:0] v, input logic [2:0] c);
        for (int i = 0; i < NLR; i++)
            if (m_st[i][1] && m_vid[i] == v && m_cpu[i] == c) return i;
        return -1;
    endfunction

    task automatic load(input int i, input logic [9:0] v, input logic [2:0] c,
                        input logic [PW-1:0] p, input logic [1:0] s, input bit h, input bit n);
        @(negedge clk);
        lr_we = 1; lr_idx = IW'(i); lr_vid = v; lr_cpu = c; lr_prio = p;
        lr_st = s; lr_hw = h; lr_notify = n;
        @(negedge clk);
        lr_we = 0;
        m_vid[i] = v; m_cpu[i] = c; m_prio[i] = p; m_st[i] = s; m_hw[i] = h; m_nt[i] = n;
        chk(lr_state == m_pack(), "R10 load", 32'(lr_state), 32'(m_pack()));
    endtask

    task automatic clear_all();
        for (int i = 0; i < NLR; i++) load(i, 10'd0, 3'd0, '0, 2'b00, 0, 0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [12:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
        if (a == 2'd0) m_en = d[0];
        if (a == 2'd1) m_pm = d[PW-1:0];
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata; e = ack_hw_err;
        chk(bus_rvalid == 1'b1, "R2 rvalid", 32'(bus_rvalid), 32'd1);
        bus_req = 0;
    endtask

    task automatic do_ack(input string tag);
        logic [31:0] d; logic e; logic [31:0] xd; logic xe;
        int w = m_win();
        xe = 0; xd = 32'd1023;
        if (m_en && w >= 0) begin
            if (m_hw[w]) xe = 1;
            else begin xd = 32'({m_cpu[w], m_vid[w]}); m_st[w] = 2'b10; end
        end
        rd(2'd2, d, e);
        chk(d == xd, {tag, " data"}, d, xd);
        chk(e == xe, "R8 err flag", 32'(e), 32'(xe));
        chk(lr_state == m_pack(), {tag, " state"}, 32'(lr_state), 32'(m_pack()));
    endtask

    task automatic do_eoi(input logic [9:0] v, input logic [2:0] c, input string tag);
        int m = m_match(v, c);
        bit xp = 0;
        if (m >= 0) begin
            xp = m_nt[m];
            m_st[m] = (m_st[m] == 2'b11) ? 2'b01 : 2'b00;
        end
        wr(2'd3, {c, v});
        chk(eoi_pulse == xp, "R9 pulse", 32'(eoi_pulse), 32'(xp));
        if (xp) chk(eoi_idx == IW'(m), "R9 index", 32'(eoi_idx), 32'(m));
        chk(lr_state == m_pack(), {tag, " state"}, 32'(lr_state), 32'(m_pack()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d; logic e; int r;
        r = $urandom(32'd20240);
        for (int i = 0; i < NLR; i++) begin
            m_vid[i] = 0; m_cpu[i] = 0; m_prio[i] = 0; m_st[i] = 0; m_hw[i] = 0; m_nt[i] = 0;
        end
        m_en = 0; m_pm = '1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(lr_state == '0, "R1 states", 32'(lr_state), 32'd0);
        chk(bus_rvalid == 0, "R1 rvalid", 32'(bus_rvalid), 32'd0);
        chk(ack_hw_err == 0 && eoi_pulse == 0, "R1 pulses", {30'd0, ack_hw_err, eoi_pulse}, 32'd0);
        rd(2'd0, d, e); chk(d == 32'd0, "R1 enable", d, 32'd0);
        rd(2'd1, d, e); chk(d == 32'd31, "R1 pmask", d, 32'd31);

        // R3 disabled interface
        load(2, 10'd77, 3'd5, 5'd3, 2'b01, 0, 0);
        do_ack("R3 disabled");
        // R2 register round trip
        wr(2'd0, 13'h1fff); rd(2'd0, d, e); chk(d == 32'd1, "R2 ctrl", d, 32'd1);
        wr(2'd1, 13'd9);    rd(2'd1, d, e); chk(d == 32'd9, "R2 pmask", d, 32'd9);
        // R4 basic grant
        do_ack("R4 grant");
        do_ack("R3 none pending");
        // R5 tie to lowest index, lower prio beats lower index
        clear_all();
        load(3, 10'd30, 3'd3, 5'd4, 2'b01, 0, 0);
        load(1, 10'd10, 3'd1, 5'd4, 2'b01, 0, 0);
        load(0, 10'd5,  3'd0, 5'd6, 2'b01, 0, 0);
        do_ack("R5 tie");
        do_ack("R5 prio");
        // R5 mask boundary: prio 6 equals mask, not eligible
        wr(2'd1, 13'd6);
        do_ack("R5 mask edge");
        wr(2'd1, 13'd7);
        do_ack("R5 below mask");
        // R8 hardware-linked winner
        load(2, 10'd99, 3'd2, 5'd1, 2'b01, 1, 0);
        do_ack("R8 hw");
        @(negedge clk);
        chk(ack_hw_err == 0, "R8 one cycle", 32'(ack_hw_err), 32'd0);
        load(2, 10'd99, 3'd2, 5'd1, 2'b00, 0, 0);
        // R6 and R9: pending-and-active, notify
        load(1, 10'd10, 3'd1, 5'd4, 2'b11, 0, 1);
        do_eoi(10'd10, 3'd2, "R7 cpu mismatch");
        do_eoi(10'd10, 3'd1, "R6 pact");
        @(negedge clk);
        chk(eoi_pulse == 0, "R9 one cycle", 32'(eoi_pulse), 32'd0);
        do_eoi(10'd30, 3'd3, "R6 active no notify");
        do_eoi(10'd30, 3'd3, "R7 stale");
        // R6 duplicate match goes to lowest index
        load(0, 10'd44, 3'd4, 5'd2, 2'b10, 0, 1);
        load(3, 10'd44, 3'd4, 5'd2, 2'b10, 0, 1);
        do_eoi(10'd44, 3'd4, "R6 lowest");
        // R10 load overrides same-cycle acknowledge
        clear_all();
        load(1, 10'd12, 3'd6, 5'd1, 2'b01, 0, 0);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = 2'd2;
        lr_we = 1; lr_idx = 2'd1; lr_vid = 10'd13; lr_cpu = 3'd6; lr_prio = 5'd2;
        lr_st = 2'b01; lr_hw = 0; lr_notify = 0;
        @(negedge clk);
        bus_req = 0; lr_we = 0;
        chk(bus_rdata == 32'({3'd6, 10'd12}), "R10 ack data", bus_rdata, 32'({3'd6, 10'd12}));
        chk(lr_state == 8'b0000_0100, "R10 override", 32'(lr_state), 32'h4);
        m_vid[1] = 10'd13; m_prio[1] = 5'd2; m_st[1] = 2'b01;

        // Random mix, R4 R5 R6 R7 R9
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom_range(0, 9));
            if (op < 3) begin
                load(int'($urandom_range(0, NLR-1)), 10'($urandom_range(0, 3)), 3'($urandom_range(0, 1)),
                     PW'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
                     $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1);
            end else if (op < 6) begin
                do_ack("R4 R5 random");
            end else if (op < 9) begin
                do_eoi(10'($urandom_range(0, 3)), 3'($urandom_range(0, 1)), "R6 R7 random");
            end else begin
                wr(2'd1, 13'($urandom_range(3, 9)));
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule